// File: doc/BRIEF.md
# Four-Line Cache Tag Status Tracker

This block holds the tag state of a small, fully associative cache with four lines. For every line it keeps a tag, a valid flag, a one-hot record of which kind of request last loaded the line, and a 2-bit recency rank. The ranks always form a permutation of 0..3. Rank 0 is the most recently touched line and rank 3 is the least recently touched.

A controller probes the tracker with a lookup tag and receives a hit flag and the matching line. The tracker reports a replacement victim at all times. A fill writes a new tag into that victim and records why the line was loaded. An invalidate drops a chosen line. Hits and fills move the touched line to rank 0.

Each line also exposes a read-only 32-bit diagnostic word that packs its valid flag, cause flags and rank. Within one cycle the tracker applies the fill first, then the lookup, then the invalidate.

Top module: `cts_tracker`

## Requirements
- R1: After reset every line is invalid, with no cause flags set. The ranks of lines 0, 1, 2 and 3 are 0, 1, 2 and 3, so their status words read 0x00, 0x10, 0x20 and 0x30.
- R2: Each status word carries these fields:
  - bit 31: valid flag;
  - bits 11..8: cause flags;
  - bits 5..4: recency rank;
  - every other bit reads zero.
- R3: A fill writes the fill tag into the current victim line and sets its valid flag. It sets exactly one cause flag from the 2-bit cause code: code 0 (bus read) sets bit 11, code 1 (predictive fill) sets bit 10, code 2 (receive-queue advice) sets bit 9, and code 3 (bus write) sets bit 8. The other three flags are cleared.
- R4: A hit or a fill gives the touched line rank 0. Every line whose rank was below the touched line's old rank goes up by one, and all other ranks are unchanged.
- R5: The victim output names the lowest-numbered invalid line. When all four lines are valid, it names the line with rank 3.
- R6: While a lookup is requested, the hit output is high exactly when a valid line holds the lookup tag, and the line output gives that line's index. Invalid lines never hit.
- R7: An invalidate clears the line's valid flag and cause flags and keeps its rank. Afterwards, a lookup of the old tag misses.
- R8: When a fill and a lookup occur in the same cycle, the fill is applied first. A lookup of the tag being filled therefore hits the filled line, and the rank update for the lookup starts from the ranks produced by the fill.
- R9: A lookup must never match more than one valid line. The user guarantees this by never filling a tag that is already valid.
- R10: Status words show the registered state directly, so an update becomes visible right after the clock edge that applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | 20 | Lookup tag |
| lk_hit | output | 1 | Lookup hit (after any same-cycle fill) |
| lk_line | output | 2 | Index of the line that hit |
| fill_valid | input | 1 | Fill request into the victim line |
| fill_tag | input | 20 | Tag to be filled |
| fill_cause | input | 2 | Load cause code: 0 bus read, 1 predictive, 2 receive-queue advice, 3 bus write |
| inv_valid | input | 1 | Invalidate request |
| inv_line | input | 2 | Line to invalidate |
| victim_line | output | 2 | Current replacement victim |
| status_words | output | 128 | Four 32-bit status words; line n occupies bits 32n+31..32n |

## Verification
The bench first fills all four lines with every cause code. This separates the flag positions and shows how victim choice passes from invalid lines to rank-based replacement. A long lookup sweep then visits every line in an irregular order and mixes in misses. Comparing all four ranks after each step against an arithmetic model tells a correct shift of lower ranks apart from an off-by-one or a wrong comparison direction. Invalidates followed by refills show that the lowest invalid line is chosen ahead of the line with rank 3. Same-cycle fill and lookup pairs, some on the new tag and some on an old one, show the fill-first ordering.

// File: rtl/cts_pkg.sv
package cts_pkg;

    localparam int NUM_LINES = 4;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int RANK_W    = IDX_W;
    localparam int TAG_W     = 20;
    localparam int WORD_W    = 32;
    localparam int CAUSES    = 4;

    localparam int VALID_BIT = WORD_W - 1;
    localparam int CAUSE_LO  = 8;
    localparam int RANK_LO   = 4;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CAUSES-1:0] cause_flags_t;

    typedef enum logic [1:0] {
        CAUSE_BUS_RD   = 2'd0,
        CAUSE_PREFETCH = 2'd1,
        CAUSE_RXQ_HINT = 2'd2,
        CAUSE_BUS_WR   = 2'd3
    } cause_e;

    typedef struct packed {
        logic         valid;
        cause_flags_t cause;
        tag_t         tag;
    } line_st_t;

    typedef line_st_t [NUM_LINES-1:0] line_vec_t;
    typedef rank_t    [NUM_LINES-1:0] rank_vec_t;

    localparam rank_t RANK_LRU = rank_t'(NUM_LINES - 1);

    // code 0 lands on the top flag (word bit 11), code 3 on the bottom (bit 8)
    function automatic cause_flags_t cause_onehot(cause_e c);
        cause_flags_t f;
        f = '0;
        f[CAUSES-1-int'(c)] = 1'b1;
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(line_st_t l, rank_t r);
        logic [WORD_W-1:0] w;
        w = '0;
        w[VALID_BIT]              = l.valid;
        w[CAUSE_LO +: CAUSES]     = l.cause;
        w[RANK_LO +: RANK_W]      = r;
        return w;
    endfunction

endpackage

// File: rtl/cts_match.sv
module cts_match
    import cts_pkg::*;
(
    input  line_vec_t              lines,
    input  tag_t                   probe,
    output logic [NUM_LINES-1:0]   match_vec,
    output logic                   any_match,
    output idx_t                   match_idx
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
        assign match_vec[i] = lines[i].valid && (lines[i].tag == probe);
    end

    assign any_match = |match_vec;

    always_comb begin
        match_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (match_vec[i]) match_idx = idx_t'(i);
        end
    end

endmodule

// File: rtl/cts_victim.sv
module cts_victim
    import cts_pkg::*;
(
    input  line_vec_t lines,
    input  rank_vec_t ranks,
    output idx_t      victim
);

    logic found_free;
    idx_t free_idx;
    idx_t lru_idx;

    always_comb begin
        found_free = 1'b0;
        free_idx   = '0;
        lru_idx    = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (ranks[i] == RANK_LRU) lru_idx = idx_t'(i);
        end
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (!lines[i].valid) begin
                found_free = 1'b1;
                free_idx   = idx_t'(i);
            end
        end
        victim = found_free ? free_idx : lru_idx;
    end

endmodule

// File: rtl/cts_rank_touch.sv
module cts_rank_touch
    import cts_pkg::*;
(
    input  rank_vec_t ranks_in,
    input  logic      touch,
    input  idx_t      line,
    output rank_vec_t ranks_out
);

    rank_t old_rank;
    assign old_rank = ranks_in[line];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
        always_comb begin
            if (!touch) begin
                ranks_out[i] = ranks_in[i];
            end else if (idx_t'(i) == line) begin
                ranks_out[i] = '0;
            end else if (ranks_in[i] < old_rank) begin
                ranks_out[i] = ranks_in[i] + rank_t'(1);
            end else begin
                ranks_out[i] = ranks_in[i];
            end
        end
    end

endmodule

// File: rtl/cts_tracker.sv
module cts_tracker
    import cts_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          lk_valid,
    input  logic [TAG_W-1:0]              lk_tag,
    output logic                          lk_hit,
    output logic [IDX_W-1:0]              lk_line,
    input  logic                          fill_valid,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [1:0]                    fill_cause,
    input  logic                          inv_valid,
    input  logic [IDX_W-1:0]              inv_line,
    output logic [IDX_W-1:0]              victim_line,
    output logic [NUM_LINES*WORD_W-1:0]   status_words
);

    line_vec_t lines_q, lines_f, lines_d;
    rank_vec_t ranks_q, ranks_f, ranks_d;
    logic [NUM_LINES-1:0] match_vec;
    logic any_match;

    // stage 1: fill into the victim of the registered state
    cts_victim u_victim (
        .lines  (lines_q),
        .ranks  (ranks_q),
        .victim (victim_line)
    );

    cts_rank_touch u_touch_fill (
        .ranks_in  (ranks_q),
        .touch     (fill_valid),
        .line      (victim_line),
        .ranks_out (ranks_f)
    );

    always_comb begin
        lines_f = lines_q;
        if (fill_valid) begin
            lines_f[victim_line].valid = 1'b1;
            lines_f[victim_line].cause = cause_onehot(cause_e'(fill_cause));
            lines_f[victim_line].tag   = fill_tag;
        end
    end

    // stage 2: lookup sees the post-fill state
    cts_match u_match (
        .lines     (lines_f),
        .probe     (lk_tag),
        .match_vec (match_vec),
        .any_match (any_match),
        .match_idx (lk_line)
    );

    assign lk_hit = lk_valid && any_match;

    cts_rank_touch u_touch_look (
        .ranks_in  (ranks_f),
        .touch     (lk_hit),
        .line      (lk_line),
        .ranks_out (ranks_d)
    );

    // stage 3: invalidate, rank untouched
    always_comb begin
        lines_d = lines_f;
        if (inv_valid) begin
            lines_d[inv_line].valid = 1'b0;
            lines_d[inv_line].cause = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) ranks_q[i] <= rank_t'(i);
        end else begin
            lines_q <= lines_d;
            ranks_q <= ranks_d;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_word
        assign status_words[i*WORD_W +: WORD_W] = status_word(lines_q[i], ranks_q[i]);
    end

    // ---------------- assertions ----------------
    logic [NUM_LINES-1:0] rank_seen;
    logic [NUM_LINES-1:0] valid_vec;

    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            rank_seen[ranks_q[i]] = 1'b1;
            valid_vec[i] = lines_q[i].valid;
        end
    end

    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
        rank_seen == '1); // R4

    AST_HIT_BECOMES_MRU: assert property (@(posedge clk) disable iff (rst)
        lk_hit |=> ranks_q[$past(lk_line)] == '0); // R4

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $countones(match_vec) <= 1); // R9

    AST_FILL_SETS_LINE: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !(inv_valid && inv_line == victim_line))
        |=> lines_q[$past(victim_line)].valid
            && $countones(lines_q[$past(victim_line)].cause) == 1); // R3

    AST_INVALIDATE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        inv_valid |=> !lines_q[$past(inv_line)].valid
                      && lines_q[$past(inv_line)].cause == '0); // R7

    AST_VICTIM_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        !(&valid_vec) |-> !lines_q[victim_line].valid); // R5

    AST_VICTIM_LRU_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (&valid_vec) |-> ranks_q[victim_line] == RANK_LRU); // R5

endmodule

// File: tb/sim_cts_tracker.sv
module sim_cts_tracker;

    logic         clk = 1'b0;
    logic         rst;
    logic         lk_valid;
    logic [19:0]  lk_tag;
    logic         lk_hit;
    logic [1:0]   lk_line;
    logic         fill_valid;
    logic [19:0]  fill_tag;
    logic [1:0]   fill_cause;
    logic         inv_valid;
    logic [1:0]   inv_line;
    logic [1:0]   victim_line;
    logic [127:0] status_words;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    logic        m_val  [4];
    logic [19:0] m_tag  [4];
    logic [3:0]  m_flag [4];
    logic [1:0]  m_rank [4];

    always #4 clk = ~clk; // 125 MHz

    cts_tracker u0 (
        .clk          (clk),
        .rst          (rst),
        .lk_valid     (lk_valid),
        .lk_tag       (lk_tag),
        .lk_hit       (lk_hit),
        .lk_line      (lk_line),
        .fill_valid   (fill_valid),
        .fill_tag     (fill_tag),
        .fill_cause   (fill_cause),
        .inv_valid    (inv_valid),
        .inv_line     (inv_line),
        .victim_line  (victim_line),
        .status_words (status_words)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int i);
        logic [31:0] w;
        w = '0;
        w[31]   = m_val[i];
        w[11:8] = m_flag[i];
        w[5:4]  = m_rank[i];
        return w;
    endfunction

    task automatic check_words(input string req);
        for (int i = 0; i < 4; i++) begin
            check(status_words[i*32 +: 32] === exp_word(i), req,
                  $sformatf("status word %0d", i), status_words[i*32 +: 32], exp_word(i));
        end
    endtask

    task automatic m_touch(input int t);
        logic [1:0] old;
        old = m_rank[t];
        for (int i = 0; i < 4; i++) begin
            if (i == t) m_rank[i] = 2'd0;
            else if (m_rank[i] < old) m_rank[i] = m_rank[i] + 2'd1;
        end
    endtask

    function automatic int m_victim();
        for (int i = 0; i < 4; i++) if (!m_val[i]) return i;
        for (int i = 0; i < 4; i++) if (m_rank[i] == 2'd3) return i;
        return 0;
    endfunction

    task automatic step(input logic fv, input logic [19:0] ft, input logic [1:0] fc,
                        input logic lv, input logic [19:0] lt,
                        input logic iv, input logic [1:0] il, input string req);
        int  v;
        bit  eh;
        int  el;
        @(negedge clk);
        fill_valid = fv; fill_tag = ft; fill_cause = fc;
        lk_valid = lv;   lk_tag = lt;
        inv_valid = iv;  inv_line = il;
        #1;
        v = m_victim();
        check(victim_line === 2'(v), "R5", "victim", 32'(victim_line), 32'(v));
        if (fv) begin
            m_tag[v] = ft; m_val[v] = 1'b1; m_flag[v] = 4'b1000 >> fc;
            m_touch(v);
        end
        eh = 1'b0; el = 0;
        for (int i = 0; i < 4; i++) begin
            if (lv && m_val[i] && m_tag[i] == lt) begin eh = 1'b1; el = i; end
        end
        check(lk_hit === eh, {req, " R6"}, "lookup hit", 32'(lk_hit), 32'(eh));
        if (eh) begin
            check(lk_line === 2'(el), {req, " R6"}, "lookup line", 32'(lk_line), 32'(el));
            m_touch(el);
        end
        if (iv) begin m_val[il] = 1'b0; m_flag[il] = 4'b0; end
        @(posedge clk);
        #1;
        check_words({req, " R10"});
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        lk_valid = 0; lk_tag = '0; fill_valid = 0; fill_tag = '0; fill_cause = '0;
        inv_valid = 0; inv_line = '0;
        for (int i = 0; i < 4; i++) begin
            m_val[i] = 0; m_tag[i] = '0; m_flag[i] = '0; m_rank[i] = 2'(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: fixed reset image
        for (int i = 0; i < 4; i++) begin
            check(status_words[i*32 +: 32] === 32'(i * 16), "R1",
                  $sformatf("reset word %0d", i), status_words[i*32 +: 32], 32'(i * 16));
        end
        check(victim_line === 2'd0, "R1 R5", "reset victim", 32'(victim_line), 0);

        // R3 R2: fill all lines, one per cause code
        for (int c = 0; c < 4; c++) step(1, 20'h100 + 20'(c), 2'(c), 0, '0, 0, '0, "R3 R2");

        // R4 R6 R9: irregular lookup sweep with misses
        for (int k = 0; k < 48; k++) begin
            int sel;
            sel = (k * 7 + k / 3) % 5;
            step(0, '0, '0, 1, (sel == 4) ? 20'hDEAD : m_tag[sel], 0, '0, "R4 R9");
        end

        // R7: invalidate keeps rank, old tag then misses
        step(0, '0, '0, 0, '0, 1, 2'd2, "R7");
        step(0, '0, '0, 1, 20'h102, 0, '0, "R7");

        // R5: freed line is refilled before the rank-3 line
        step(1, 20'h200, 2'd1, 0, '0, 0, '0, "R5 R3");

        // R8: fill and lookup together
        step(1, 20'h300, 2'd2, 1, 20'h300, 0, '0, "R8");
        step(1, 20'h301, 2'd3, 1, m_tag[0], 0, '0, "R8 R4");

        // R7 R5: two holes, lowest first
        step(0, '0, '0, 0, '0, 1, 2'd3, "R7");
        step(0, '0, '0, 0, '0, 1, 2'd0, "R7");
        step(1, 20'h500, 2'd0, 0, '0, 0, '0, "R5");
        step(1, 20'h501, 2'd3, 0, '0, 0, '0, "R5");

        // R3 R8: cause sweep over a full store, lookup of the previous tag
        for (int k = 0; k < 12; k++) begin
            step(1, 20'h600 + 20'(k), 2'(k % 4), 1, 20'h600 + 20'(k) - 20'd1, 0, '0, "R3 R8");
        end

        @(negedge clk);
        fill_valid = 0; lk_valid = 0; inv_valid = 0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule